// File: doc/BRIEF.md
# Clear-on-Read Ethernet Event Statistics Bank

This block keeps a set of event counters for an Ethernet receive and transmit path. The MAC datapath raises a one-cycle pulse on a dedicated event line each time something of interest happens. Examples are a frame with a bad checksum, a receive fault, a collision, a good, broadcast or multicast frame received, and any frame received or sent. Each pulse adds one to the matching counter. A counter stops at its all-ones value and does not wrap.

Software reaches the counters through a request/response register port. An accepted read returns the counter's current value one cycle later and sets that counter back to zero in the same step. An event that arrives in the same cycle as the clearing read is kept: the counter is left at one. Writes are accepted and discarded. Reads that fall on a hole in the counter window, or outside it, return zero and change nothing.

The request side uses valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The response side also uses valid/ready. `rsp_valid` and `rsp_data` stay fixed until `rsp_ready` is seen high. While a response is still waiting, `req_ready` is low, so the bank holds at most one read in flight.

Top module: `evt_stats_bank`

## Requirements
- R1: After reset every counter reads zero, and `rsp_valid` is low.
- R2: A pulse on `evt_pulse[i]` adds one to counter i. The counters sit at these byte addresses: bit 0 at 0x4000 (checksum errors), bit 1 at 0x400C (receive errors), bit 2 at 0x4014 (single collisions), bit 3 at 0x4018 (excessive collisions), bit 4 at 0x4074 (good received), bit 5 at 0x4078 (broadcast received), bit 6 at 0x407C (multicast received), bit 7 at 0x40D0 (all received), bit 8 at 0x40D4 (all sent), bit 9 at 0x40F0 (multicast sent) and bit 10 at 0x40F4 (broadcast sent).
- R3: An accepted read (`req_write`=0) returns the counter's value as it was before the read, and leaves that counter at zero.
- R4: If a counter gets an event in the same cycle as its clearing read, the read returns the value before the event, and the counter is left at 1.
- R5: A counter at its all-ones value stays there when it gets more events.
- R6: A read of a word in 0x4000–0x4FFF that has no counter, or of any address outside that window, returns zero and changes no counter.
- R7: An accepted write (`req_write`=1) changes no counter and produces no response.
- R8: `rsp_valid` goes high in the cycle after a read is accepted, and `rsp_data` carries the read result in that cycle.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` does not change, `rsp_valid` stays high, and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 11 | One-cycle event strobes, one per counter |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write (discarded), 0 = read |
| req_addr | input | ADDR_W (16) | Byte address of the request |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | CNT_W (32) | Read data |

## Verification
The bench builds the bank with `CNT_W` set to 8, so that saturation is reached with a few hundred pulses rather than four billion. `ADDR_W` keeps its default of 16, which lets the bench probe addresses just below the window, just above it, and on holes inside it. Holding `rsp_ready` low for several cycles checks the back-pressure rules. Pulsing an event in the same cycle as a read of that counter checks the case where a clear and an event collide.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int N_CNT    = 11;
  localparam int WIN_BITS = 12;              // 4 KiB counter window
  localparam int WORD_W   = WIN_BITS - 2;    // word index inside the window

  // word index (byte offset / 4) of each counter inside the window
  function automatic logic [WORD_W-1:0] cnt_word(input int idx);
    case (idx)
      0:       cnt_word = 10'd0;   // 0x000 checksum errors
      1:       cnt_word = 10'd3;   // 0x00C receive errors
      2:       cnt_word = 10'd5;   // 0x014 single collisions
      3:       cnt_word = 10'd6;   // 0x018 excessive collisions
      4:       cnt_word = 10'd29;  // 0x074 good received
      5:       cnt_word = 10'd30;  // 0x078 broadcast received
      6:       cnt_word = 10'd31;  // 0x07C multicast received
      7:       cnt_word = 10'd52;  // 0x0D0 all received
      8:       cnt_word = 10'd53;  // 0x0D4 all sent
      9:       cnt_word = 10'd60;  // 0x0F0 multicast sent
      default: cnt_word = 10'd61;  // 0x0F4 broadcast sent
    endcase
  endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= inc ? W'(1) : '0;
    else if (inc && cnt != MAX) cnt <= cnt + W'(1);
  end

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt != MAX) |=> cnt == $past(cnt) + W'(1));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> cnt == '0);
  assert_keep_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> cnt == W'(1));
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt == MAX) |=> cnt == MAX);
endmodule

// File: rtl/stat_addr_decode.sv
module stat_addr_decode
  import stat_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CNT-1:0]  hit
);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic in_win;
  assign in_win = addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS];

  for (genvar g = 0; g < N_CNT; g++) begin : g_hit
    assign hit[g] = in_win && (addr[WIN_BITS-1:2] == cnt_word(g));
  end

  initial assert (TAG_W > 0);

  always_comb begin
    assert_single_hit_R6: assert ($onehot0(hit));
  end
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  output logic         req_ready,
  output logic         rd_take,
  input  logic [W-1:0] rd_value,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign rd_take   = req_valid && req_ready && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rsp_valid);
  assert_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/evt_stats_bank.sv
module evt_stats_bank
  import stat_pkg::*;
#(
  parameter int                CNT_W    = 32,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CNT-1:0]  evt_pulse,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CNT_W-1:0]  rsp_data
);
  logic [N_CNT-1:0] hit;
  logic             rd_take;
  logic [CNT_W-1:0] cnt [N_CNT];
  logic [CNT_W-1:0] rd_value;

  stat_addr_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr (req_addr),
    .hit  (hit)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    stat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (evt_pulse[g]),
      .clr   (rd_take && hit[g]),
      .cnt   (cnt[g])
    );
  end

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < N_CNT; i++)
      if (hit[i]) rd_value |= cnt[i];
  end

  stat_read_port #(.W(CNT_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rd_take   (rd_take),
    .rd_value  (rd_value),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && hit == '0) |=> rsp_data == '0);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);
endmodule

// File: tb/test_evt_stats_bank.sv
module test_evt_stats_bank;
  localparam int N  = 11;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_pulse = '0;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0]   req_addr = '0;
  logic          req_ready, rsp_valid;
  logic [CW-1:0] rsp_data;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  evt_stats_bank #(.CNT_W(CW)) i_evt_stats_bank (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] m, input int reps);
    for (int k = 0; k < reps; k++) begin
      @(negedge clk) evt_pulse = m;
    end
    @(negedge clk) evt_pulse = '0;
  endtask

  // read with optional same-cycle event; returns data sampled one cycle later
  task automatic rd(input logic [15:0] a, input logic [N-1:0] m,
                    output int data, output bit vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; evt_pulse = m;
    @(negedge clk);
    req_valid = 1'b0; evt_pulse = '0;
    data = int'(rsp_data); vld = rsp_valid;
  endtask

  // table: mask[42:32] reps[31:24] addr[23:8] expected[7:0]
  localparam logic [42:0] TBL [12] = '{
    {11'h001, 8'd3, 16'h4000, 8'd3},
    {11'h002, 8'd5, 16'h400C, 8'd5},
    {11'h00C, 8'd2, 16'h4014, 8'd2},
    {11'h000, 8'd0, 16'h4018, 8'd2},
    {11'h070, 8'd7, 16'h4074, 8'd7},
    {11'h000, 8'd0, 16'h4078, 8'd7},
    {11'h000, 8'd0, 16'h407C, 8'd7},
    {11'h180, 8'd4, 16'h40D0, 8'd4},
    {11'h000, 8'd0, 16'h40D4, 8'd4},
    {11'h600, 8'd1, 16'h40F0, 8'd1},
    {11'h000, 8'd0, 16'h40F4, 8'd1},
    {11'h000, 8'd0, 16'h4000, 8'd0}   // R3: cleared by the first row's read
  };

  localparam logic [15:0] ADDRS [11] = '{16'h4000, 16'h400C, 16'h4014,
    16'h4018, 16'h4074, 16'h4078, 16'h407C, 16'h40D0, 16'h40D4, 16'h40F0,
    16'h40F4};

  initial begin
    int d; bit v; int held;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      rd(ADDRS[i], '0, d, v);
      check("R1 counter after reset", d, 0);
    end

    // table walk (R2, R3, R8)
    for (int t = 0; t < 12; t++) begin
      if (TBL[t][31:24] != 0) pulse(TBL[t][42:32], int'(TBL[t][31:24]));
      rd(TBL[t][23:8], '0, d, v);
      check("R8 rsp_valid after read", int'(v), 1);
      check(t == 11 ? "R3 cleared value" : "R2 count", d, int'(TBL[t][7:0]));
    end

    // R4: event in the same cycle as the clearing read
    pulse(11'h001, 2);
    rd(16'h4000, 11'h001, d, v);
    check("R4 pre-event value", d, 2);
    rd(16'h4000, '0, d, v);
    check("R4 counter left at 1", d, 1);

    // R5: saturation
    pulse(11'h002, 300);
    rd(16'h400C, '0, d, v);
    check("R5 saturated", d, 255);
    rd(16'h400C, '0, d, v);
    check("R5 cleared after saturation", d, 0);

    // R6: holes and outside-window reads
    pulse(11'h001, 3);
    rd(16'h4004, '0, d, v);  check("R6 hole reads zero", d, 0);
    rd(16'h4FFC, '0, d, v);  check("R6 window top reads zero", d, 0);
    rd(16'h5000, '0, d, v);  check("R6 above window zero", d, 0);
    rd(16'h3000, '0, d, v);  check("R6 below window zero", d, 0);
    rd(16'h4000, '0, d, v);  check("R6 no side effect", d, 3);

    // R7: writes are discarded
    pulse(11'h004, 4);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h4014;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R7 no response to write", int'(rsp_valid), 0);
    rd(16'h4014, '0, d, v);  check("R7 count kept", d, 4);

    // R9: back-pressure
    pulse(11'h100, 6);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 16'h40D4;
    @(negedge clk);
    req_valid = 1'b0;
    held = int'(rsp_data);
    check("R9 data under stall", held, 6);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 rsp_valid held", int'(rsp_valid), 1);
      check("R9 rsp_data stable", int'(rsp_data), held);
      check("R9 req_ready low", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 response drained", int'(rsp_valid), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule